// File: doc/BRIEF.md
# Effective Address Generator for an 8-bit Processor

This block turns an addressing-mode code, up to two operand bytes, the two index registers and the program counter into a 16-bit target address. It covers the common modes of a classic 8-bit accumulator processor:

- page-zero direct and page-zero indexed
- absolute direct and absolute indexed
- three kinds of page-zero pointer indirection
- the pointer jump and the indexed pointer jump
- relative branches

Every wrap and carry rule of those modes is kept, including the flaw of the pointer jump. When it reads its second pointer byte, that jump never leaves the page of the first byte.

The instruction decoder places a request by raising `start` for one cycle while `busy` is low. Direct modes return their address one cycle later. Pointer modes read two bytes through a byte-wide memory port with one cycle of read latency, low byte first, and then return the assembled address. `busy` stays high while a pointer walk is in progress, and any request offered during that time is dropped. Each accepted request produces exactly one `valid` pulse, with the address on `ea_out` in the same cycle.

Top module: `eff_addr_gen`

## Requirements
- R1: Mode code 0 gives {0x00, op_lo}. Code 1 gives {0x00, (op_lo+x) mod 256} and code 2 gives {0x00, (op_lo+y) mod 256}, so the result never leaves page zero.
- R2: Code 3 gives {op_hi, op_lo}. Code 4 adds x and code 5 adds y to that word, with carry into the high byte and the total taken modulo 65536.
- R3: Code 6 forms p = (op_lo+x) mod 256, reads the low byte at {0x00,p}, reads the high byte at {0x00,(p+1) mod 256}, and returns {high, low}.
- R4: Code 7 reads its pointer at {0x00,op_lo} and {0x00,(op_lo+1) mod 256}, then adds y to the whole 16-bit pointer modulo 65536.
- R5: Code 8 reads its pointer at {0x00,op_lo} and {0x00,(op_lo+1) mod 256} and returns it unchanged.
- R6: Code 9 reads the low target byte at {op_hi,op_lo} and the high target byte at {op_hi,(op_lo+1) mod 256}. The high byte always comes from the same page, so a pointer at 0x80FF takes its high byte from 0x8000.
- R7: Code 10 forms w = ({op_hi,op_lo}+x) mod 65536 and reads its target bytes at w and (w+1) mod 65536, crossing pages normally.
- R8: Code 11 returns (pc + sign-extended op_lo) mod 65536, where pc is the address that follows the offset byte.
- R9: A direct mode (codes 0–5, 11–15) raises `valid` in the cycle after it is accepted. A pointer mode (codes 6–10) raises `mem_rd` for exactly two consecutive cycles, starting the cycle after acceptance, low byte first. `mem_data` carries each byte one cycle after its request, and `valid` rises one cycle after the high byte arrives, four cycles after acceptance.
- R10: `busy` is high from the cycle after a pointer mode is accepted until the cycle of its `valid`, never together with `valid`. A `start` while `busy` is high is ignored.
- R11: Each accepted request produces exactly one `valid` cycle, and results come out in request order.
- R12: Unused codes 12–15 behave as code 3.
- R13: While reset is asserted and directly after it, `valid`, `busy` and `mem_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted when busy is low |
| mode | input | 4 | Addressing-mode code (see requirements) |
| op_lo | input | 8 | First operand byte (page-zero address, low address byte or branch offset) |
| op_hi | input | 8 | Second operand byte (high address byte) |
| x_idx | input | 8 | X index register value |
| y_idx | input | 8 | Y index register value |
| pc_next | input | 16 | Program counter after the operand bytes |
| mem_rd | output | 1 | Pointer-byte read request |
| mem_addr | output | 16 | Pointer-byte read address |
| mem_data | input | 8 | Read data, one cycle after the request |
| busy | output | 1 | Pointer walk in progress |
| valid | output | 1 | One-cycle result strobe |
| ea_out | output | 16 | Effective address or jump/branch target |

## Verification
The assertions assume that memory answers every read with data exactly one cycle later, and that the mode, operand and index inputs are stable in the cycle `start` is accepted. The bench models memory as a registered lookup whose byte depends on every address bit, so a same-page read and a next-page read return different values. It drives new requests only at falling edges once `busy` has dropped, except in the deliberate case that offers conflicting requests while a pointer walk runs. Operands are chosen to sit on the wrap points: 0xFF in page zero, 0xFF low bytes, the top of the address space, and negative and positive branch offsets.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [3:0] {
    AM_ZP   = 4'd0,
    AM_ZPX  = 4'd1,
    AM_ZPY  = 4'd2,
    AM_ABS  = 4'd3,
    AM_ABSX = 4'd4,
    AM_ABSY = 4'd5,
    AM_IZX  = 4'd6,
    AM_IZY  = 4'd7,
    AM_IZP  = 4'd8,
    AM_JIND = 4'd9,
    AM_JINX = 4'd10,
    AM_REL  = 4'd11
  } am_e;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_LO   = 2'd1,
    PS_HI   = 2'd2,
    PS_FIN  = 2'd3
  } ps_e;
endpackage

// File: rtl/eag_decode.sv
module eag_decode
  import eag_pkg::*;
#(
  parameter int DW = 8
) (
  input  am_e               mode,
  input  logic [DW-1:0]     op_lo,
  input  logic [DW-1:0]     op_hi,
  input  logic [DW-1:0]     ix,
  input  logic [DW-1:0]     iy,
  input  logic [2*DW-1:0]   pc,
  output logic [2*DW-1:0]   direct_ea,
  output logic [2*DW-1:0]   ptr_lo_addr,
  output logic [2*DW-1:0]   ptr_hi_addr,
  output logic              indirect,
  output logic              post_y
);
  localparam int AW = 2 * DW;
  localparam logic [DW-1:0] PAGE0 = '0;

  logic [DW-1:0] zsum_x, zsum_y, zsum_x_inc, zlo_inc;
  logic [AW-1:0] opw, abs_x, abs_y, jx, jx_inc, rel_t;
  logic [AW-1:0] off_sext;

  assign zsum_x     = op_lo + ix;
  assign zsum_y     = op_lo + iy;
  assign zsum_x_inc = zsum_x + 1'b1;
  assign zlo_inc    = op_lo + 1'b1;
  assign opw        = {op_hi, op_lo};
  assign abs_x      = opw + {PAGE0, ix};
  assign abs_y      = opw + {PAGE0, iy};
  assign jx         = abs_x;
  assign jx_inc     = jx + 1'b1;
  assign off_sext   = {{DW{op_lo[DW-1]}}, op_lo};
  assign rel_t      = pc + off_sext;

  always_comb begin
    direct_ea   = opw;
    ptr_lo_addr = opw;
    ptr_hi_addr = opw;
    indirect    = 1'b0;
    post_y      = 1'b0;
    case (mode)
      AM_ZP:   direct_ea = {PAGE0, op_lo};
      AM_ZPX:  direct_ea = {PAGE0, zsum_x};
      AM_ZPY:  direct_ea = {PAGE0, zsum_y};
      AM_ABS:  direct_ea = opw;
      AM_ABSX: direct_ea = abs_x;
      AM_ABSY: direct_ea = abs_y;
      AM_REL:  direct_ea = rel_t;
      AM_IZX: begin
        indirect    = 1'b1;
        ptr_lo_addr = {PAGE0, zsum_x};
        ptr_hi_addr = {PAGE0, zsum_x_inc};
      end
      AM_IZY: begin
        indirect    = 1'b1;
        post_y      = 1'b1;
        ptr_lo_addr = {PAGE0, op_lo};
        ptr_hi_addr = {PAGE0, zlo_inc};
      end
      AM_IZP: begin
        indirect    = 1'b1;
        ptr_lo_addr = {PAGE0, op_lo};
        ptr_hi_addr = {PAGE0, zlo_inc};
      end
      AM_JIND: begin
        // high byte stays in the page of the low byte
        indirect    = 1'b1;
        ptr_lo_addr = opw;
        ptr_hi_addr = {op_hi, zlo_inc};
      end
      AM_JINX: begin
        indirect    = 1'b1;
        ptr_lo_addr = jx;
        ptr_hi_addr = jx_inc;
      end
      default: direct_ea = opw;
    endcase
  end
endmodule

// File: rtl/eag_ptr_fsm.sv
module eag_ptr_fsm
  import eag_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic [2*DW-1:0] ptr_lo_in,
  input  logic [2*DW-1:0] ptr_hi_in,
  input  logic [DW-1:0]   mem_data,
  output logic            mem_rd,
  output logic [2*DW-1:0] mem_addr,
  output logic            busy,
  output logic            fin,
  output logic [2*DW-1:0] ptr_word
);
  localparam int AW = 2 * DW;

  ps_e           state_q, state_n;
  logic [AW-1:0] lo_addr_q, hi_addr_q;
  logic [DW-1:0] lo_byte_q;
  logic          cap_lo;

  always_comb begin
    state_n = state_q;
    case (state_q)
      PS_IDLE: if (launch) state_n = PS_LO;
      PS_LO:   state_n = PS_HI;
      PS_HI:   state_n = PS_FIN;
      PS_FIN:  state_n = PS_IDLE;
      default: state_n = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_IDLE;
    else        state_q <= state_n;
  end

  always_ff @(posedge clk) begin
    if (launch) begin
      lo_addr_q <= ptr_lo_in;
      hi_addr_q <= ptr_hi_in;
    end
  end

  assign cap_lo = (state_q == PS_HI);

  always_ff @(posedge clk) begin
    if (cap_lo) lo_byte_q <= mem_data;
  end

  assign mem_rd   = (state_q == PS_LO) || (state_q == PS_HI);
  assign mem_addr = (state_q == PS_LO) ? lo_addr_q :
                    (state_q == PS_HI) ? hi_addr_q : '0;
  assign busy     = (state_q != PS_IDLE);
  assign fin      = (state_q == PS_FIN);
  assign ptr_word = {mem_data, lo_byte_q};

  // R9
  rd_start_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd) |=> mem_rd);

  // R9
  rd_two_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |=> !mem_rd);

  // R9
  fin_after_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> ($past(mem_rd) && !mem_rd));
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import eag_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [3:0]      mode,
  input  logic [DW-1:0]   op_lo,
  input  logic [DW-1:0]   op_hi,
  input  logic [DW-1:0]   x_idx,
  input  logic [DW-1:0]   y_idx,
  input  logic [2*DW-1:0] pc_next,
  output logic            mem_rd,
  output logic [2*DW-1:0] mem_addr,
  input  logic [DW-1:0]   mem_data,
  output logic            busy,
  output logic            valid,
  output logic [2*DW-1:0] ea_out
);
  localparam int AW = 2 * DW;

  am_e           mode_e, mode_q;
  logic [AW-1:0] direct_ea, ptr_lo_addr, ptr_hi_addr, ptr_word;
  logic          indirect, post_y, accept, launch, fin;
  logic          post_y_q, valid_q, valid_n, ea_en;
  logic [DW-1:0] y_q;
  logic [AW-1:0] ea_q, ea_n, y_add;

  assign mode_e = am_e'(mode);
  assign accept = start && !busy;
  assign launch = accept && indirect;

  eag_decode #(.DW(DW)) u_dec (
    .mode        (mode_e),
    .op_lo       (op_lo),
    .op_hi       (op_hi),
    .ix          (x_idx),
    .iy          (y_idx),
    .pc          (pc_next),
    .direct_ea   (direct_ea),
    .ptr_lo_addr (ptr_lo_addr),
    .ptr_hi_addr (ptr_hi_addr),
    .indirect    (indirect),
    .post_y      (post_y)
  );

  eag_ptr_fsm #(.DW(DW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .ptr_lo_in (ptr_lo_addr),
    .ptr_hi_in (ptr_hi_addr),
    .mem_data  (mem_data),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .busy      (busy),
    .fin       (fin),
    .ptr_word  (ptr_word)
  );

  assign y_add = post_y_q ? {{DW{1'b0}}, y_q} : '0;

  always_comb begin
    ea_n    = ea_q;
    ea_en   = 1'b0;
    valid_n = 1'b0;
    if (accept && !indirect) begin
      ea_n    = direct_ea;
      ea_en   = 1'b1;
      valid_n = 1'b1;
    end else if (fin) begin
      ea_n    = ptr_word + y_add;
      ea_en   = 1'b1;
      valid_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mode_q  <= AM_ZP;
    end else begin
      valid_q <= valid_n;
      if (accept) mode_q <= mode_e;
    end
  end

  always_ff @(posedge clk) begin
    if (ea_en) ea_q <= ea_n;
    if (launch) begin
      y_q      <= y_idx;
      post_y_q <= post_y;
    end
  end

  assign valid  = valid_q;
  assign ea_out = ea_q;

  // R1
  zp_result_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (mode_q == AM_ZP || mode_q == AM_ZPX || mode_q == AM_ZPY))
      |-> (ea_out[AW-1:DW] == '0));

  // R3
  zp_pointer_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && (mode_q == AM_IZX || mode_q == AM_IZY || mode_q == AM_IZP))
      |-> (mem_addr[AW-1:DW] == '0));

  // R6
  jind_same_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd) && mode_q == AM_JIND)
      |-> (mem_addr[AW-1:DW] == $past(mem_addr[AW-1:DW])));

  // R10
  busy_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && valid));

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mode_q));
endmodule

// File: tb/sim_eff_addr_gen.sv
`timescale 1ns/1ps
module sim_eff_addr_gen;
  logic        clk, rst_n, start;
  logic [3:0]  mode;
  logic [7:0]  op_lo, op_hi, x_idx, y_idx, mem_data;
  logic [15:0] pc_next, mem_addr, ea_out;
  logic        mem_rd, busy, valid;

  typedef struct {
    logic [15:0] ea;
    longint      cyc;
    string       tag;
  } item_t;

  item_t  sb[$];
  longint cyc;
  int     n_chk, n_bad, rd_seen, rd_exp;
  bit     done;

  eff_addr_gen #(.DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .op_lo(op_lo), .op_hi(op_hi), .x_idx(x_idx), .y_idx(y_idx),
    .pc_next(pc_next), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_data(mem_data), .busy(busy), .valid(valid), .ea_out(ea_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return {a[6:0], a[7]} ^ a[15:8] ^ 8'h3C;
  endfunction

  always @(posedge clk) if (mem_rd) mem_data <= memf(mem_addr);

  function automatic logic [15:0] model(input int m, input logic [7:0] lo, hi, x, y,
                                        input logic [15:0] pc);
    logic [7:0]  p, q;
    logic [15:0] w;
    case (m)
      0: return {8'h00, lo};
      1: begin p = lo + x; return {8'h00, p}; end
      2: begin p = lo + y; return {8'h00, p}; end
      4: return {hi, lo} + {8'h00, x};
      5: return {hi, lo} + {8'h00, y};
      6: begin p = lo + x; q = p + 8'h01; return {memf({8'h00, q}), memf({8'h00, p})}; end
      7: begin q = lo + 8'h01; w = {memf({8'h00, q}), memf({8'h00, lo})}; return w + {8'h00, y}; end
      8: begin q = lo + 8'h01; return {memf({8'h00, q}), memf({8'h00, lo})}; end
      9: begin q = lo + 8'h01; return {memf({hi, q}), memf({hi, lo})}; end
      10: begin w = {hi, lo} + {8'h00, x}; return {memf(w + 16'h0001), memf(w)}; end
      11: return pc + {{8{lo[7]}}, lo};
      default: return {hi, lo};
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input int m, input logic [7:0] lo, hi, x, y,
                       input logic [15:0] pc, input string tag);
    item_t it;
    bit    ptr;
    @(negedge clk);
    while (busy) @(negedge clk);
    ptr     = (m >= 6 && m <= 10);
    start   = 1'b1;
    mode    = m[3:0];
    op_lo   = lo; op_hi = hi; x_idx = x; y_idx = y; pc_next = pc;
    it.ea   = model(m, lo, hi, x, y, pc);
    it.cyc  = cyc + (ptr ? 4 : 1);
    it.tag  = tag;
    if (ptr) rd_exp += 2;
    sb.push_back(it);
  endtask

  task automatic go_idle();
    @(negedge clk);
    start = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd) rd_seen++;
      if (valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R11", "unexpected valid", 1, 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(ea_out == it.ea, it.tag, "address", ea_out, it.ea);
          check(cyc == it.cyc, "R9", {"valid cycle for ", it.tag}, cyc, it.cyc);
        end
      end
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; rd_seen = 0; rd_exp = 0; done = 1'b0;
    rst_n = 1'b0; start = 1'b0; mode = '0; op_lo = '0; op_hi = '0;
    x_idx = '0; y_idx = '0; pc_next = '0;
    repeat (3) @(negedge clk);
    // R13 reset state
    check(valid == 1'b0, "R13", "valid in reset", valid, 0);
    check(busy == 1'b0, "R13", "busy in reset", busy, 0);
    check(mem_rd == 1'b0, "R13", "mem_rd in reset", mem_rd, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid == 1'b0 && busy == 1'b0 && mem_rd == 1'b0, "R13",
          "outputs after reset", {valid, busy, mem_rd}, 0);

    // R1 page zero, including index wrap
    issue(0, 8'h37, 8'hAA, 8'h11, 8'h22, 16'h0000, "R1");
    issue(1, 8'hF0, 8'hAA, 8'h20, 8'h00, 16'h0000, "R1");
    issue(2, 8'h80, 8'h55, 8'h00, 8'h7F, 16'h0000, "R1");
    // R2 absolute and indexed carry/wrap
    issue(3, 8'h34, 8'h12, 8'h00, 8'h00, 16'h0000, "R2");
    issue(4, 8'hF0, 8'h12, 8'h20, 8'h00, 16'h0000, "R2");
    issue(5, 8'hF0, 8'hFF, 8'h00, 8'h20, 16'h0000, "R2");
    // R8 relative branches, back, forward, and across the top
    issue(11, 8'h80, 8'h00, 8'h00, 8'h00, 16'h1000, "R8");
    issue(11, 8'h7F, 8'h00, 8'h00, 8'h00, 16'h1000, "R8");
    issue(11, 8'h20, 8'h00, 8'h00, 8'h00, 16'hFFF0, "R8");
    // R12 unused codes
    issue(13, 8'hEF, 8'hBE, 8'h01, 8'h02, 16'h4321, "R12");
    issue(15, 8'h01, 8'h00, 8'h01, 8'h02, 16'h4321, "R12");
    go_idle();

    // R3 pre-indexed pointer, including wrap at 0xFF
    issue(6, 8'h10, 8'h00, 8'h05, 8'h00, 16'h0000, "R3");
    issue(6, 8'hFE, 8'h77, 8'h01, 8'h00, 16'h0000, "R3");
    // R4 post-indexed pointer, wrap on second byte and carry from Y
    issue(7, 8'hFF, 8'h00, 8'h00, 8'hF0, 16'h0000, "R4");
    issue(7, 8'h20, 8'h00, 8'h33, 8'h01, 16'h0000, "R4");
    // R5 plain page-zero pointer
    issue(8, 8'h44, 8'h99, 8'h00, 8'h00, 16'h0000, "R5");
    issue(8, 8'hFF, 8'h99, 8'h00, 8'h00, 16'h0000, "R5");
    // R6 pointer jump page flaw
    issue(9, 8'hFF, 8'h80, 8'h00, 8'h00, 16'h0000, "R6");
    issue(9, 8'h34, 8'h12, 8'h00, 8'h00, 16'h0000, "R6");
    // R7 indexed pointer jump crosses pages normally
    issue(10, 8'hFE, 8'h80, 8'h01, 8'h00, 16'h0000, "R7");
    issue(10, 8'hFF, 8'hFF, 8'h00, 8'h00, 16'h0000, "R7");
    go_idle();

    // R10: conflicting requests during a pointer walk are dropped
    issue(8, 8'h50, 8'h00, 8'h00, 8'h00, 16'h0000, "R10");
    @(negedge clk);
    mode = 4'd0; op_lo = 8'h99;
    check(busy == 1'b1, "R10", "busy during walk", busy, 1);
    @(negedge clk);
    mode = 4'd3; op_hi = 8'h12;
    check(busy == 1'b1, "R10", "busy during walk", busy, 1);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10", "busy in final step", busy, 1);
    @(negedge clk);
    check(busy == 1'b0, "R10", "busy after result", busy, 0);

    // back-to-back mix of direct after pointer
    issue(7, 8'h90, 8'h00, 8'h00, 8'h05, 16'h0000, "R4");
    issue(1, 8'hFF, 8'h00, 8'hFF, 8'h00, 16'h0000, "R1");
    go_idle();

    repeat (8) @(negedge clk);
    check(sb.size() == 0, "R11", "results outstanding", sb.size(), 0);
    check(rd_seen == rd_exp, "R9", "pointer read cycles", rd_seen, rd_exp);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule